// File: doc/BRIEF.md
# Mailbox Transmit Byte-Order Sequencer

This block holds a single transmit mailbox as a small register file. Software reaches it through a 32-bit word-wide register bus. The mailbox stores an identifier word with an extended-identifier flag, a data length code, two 32-bit data words, an enable bit, a direction bit and a global byte-order bit. Software sets the transmit request. If the mailbox is enabled and set to transmit, the block first offers the identifier and the effective length on a header port. It then offers the data bytes on a byte port, one byte per valid/ready handshake.

Bytes always come from the low data word first and then from the high data word. The byte-order bit decides whether each word is walked from its least or its most significant byte. When the last byte is accepted, the block sets the acknowledge flag and drops the request. Software clears the acknowledge flag by writing 1 to it. While a message is in progress, the register contents that define the message are protected against writes. A plain valid/ready sink takes the place of the bus, so there is no bit timing, stuffing, CRC or arbitration.

Top module: `mbx_tx_byteseq`

## Requirements
- R1: After reset, every register reads 0 and neither hdr_valid nor byte_valid is asserted.
- R2: Register map, word addresses and 32-bit access only:
  - 0: identifier, with bit 31 as the extended flag and bits 28:0 as the identifier; bits 30:29 read 0.
  - 1: length code in bits 3:0.
  - 2: low data word.
  - 3: high data word.
  - 4: bit 0 is enable and bit 1 is direction (0 means transmit).
  - 5: bit 0 is byte order.
  - 6: bit 0 is transmit request.
  - 7: bit 0 is transmit acknowledge.
  - Unlisted bits read 0.
- R3: Writing 1 to bit 0 of address 6 sets the request. Writing 0 leaves it unchanged. Software cannot clear it.
- R4: A pending request produces no header and no bytes unless enable is 1 and direction is 0. The request stays pending until then.
- R5: The header handshake carries the identifier word exactly as it reads back, together with the effective byte count. The header is accepted before the first byte is offered.
- R6: With byte order 1, the bytes go out as the low word's bytes 0,1,2,3 followed by the high word's bytes 0,1,2,3 (least significant first).
- R7: With byte order 0, the bytes go out as the low word's bytes 3,2,1,0 followed by the high word's bytes 3,2,1,0.
- R8: A length code n from 1 to 8 sends the first n bytes of that sequence. A code above 8 is treated as 8, both in the byte count and in hdr_len.
- R9: A length code of 0 sends only the header, and the message still completes.
- R10: At the clock edge that accepts the last byte (or the header when the count is 0), the acknowledge flag is set and the request is cleared. Writing 1 to acknowledge clears it. Writing 0 has no effect.
- R11: While a message is in progress, writes to the identifier, length, data words and byte-order bit are ignored.
- R12: A valid output with ready low stays valid, with unchanged data, until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| hdr_valid | output | 1 | Header offered |
| hdr_ready | input | 1 | Header accepted by the sink |
| hdr_id | output | 32 | Identifier word with the extended flag |
| hdr_len | output | 4 | Effective byte count, 0 to 8 |
| byte_valid | output | 1 | Data byte offered |
| byte_ready | input | 1 | Data byte accepted by the sink |
| byte_data | output | 8 | Data byte |

## Verification
The same pair of data words, 0x04030201 low and 0x08070605 high, is sent with both byte-order settings. Because every byte value is distinct, a swapped word order, a reversed lane order or a stuck order bit each produces a different sequence. The length codes 5, 13 and 0 show where the sequence is truncated, that long codes are clamped, and that a header-only message still completes. Three sink patterns are used: always ready, alternating ready, and ready on every third cycle. Together with writes made while the header is stalled, they separate correct stalls and write protection from data that slips or changes under the sink.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      A_IDENT = 3'd0,
      A_LEN   = 3'd1,
      A_DLO   = 3'd2,
      A_DHI   = 3'd3,
      A_CFG   = 3'd4,
      A_ORDER = 3'd5,
      A_REQ   = 3'd6,
      A_ACK   = 3'd7
   } reg_addr_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_HDR  = 2'd1,
      S_DATA = 2'd2
   } seq_state_e;

endpackage

// File: rtl/mbx_regfile.sv
module mbx_regfile
   import mbx_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int ID_W   = 29,
   parameter int LEN_W  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0]     wdata,
   output logic [WORD_W-1:0]     rdata,
   input  logic                  busy,
   input  logic                  done,
   output logic [WORD_W-1:0]     id_word,
   output logic [LEN_W-1:0]      len_code,
   output logic [WORD_W-1:0]     data_lo,
   output logic [WORD_W-1:0]     data_hi,
   output logic                  mb_en,
   output logic                  mb_dir,
   output logic                  order_lsb,
   output logic                  req,
   output logic                  ack
);

   localparam int PAD_W = WORD_W - 1 - ID_W;

   logic            ext_q;
   logic [ID_W-1:0] id_q;

   // Lay out the identifier word; the pad between flag and value may vanish.
   if (PAD_W > 0) begin : g_id_pad
      assign id_word = {ext_q, {PAD_W{1'b0}}, id_q};
   end else begin : g_id_nopad
      assign id_word = {ext_q, id_q};
   end

   logic wr_ident, wr_len, wr_dlo, wr_dhi, wr_cfg, wr_order, wr_req, wr_ack;
   assign wr_ident = we && (addr == A_IDENT);
   assign wr_len   = we && (addr == A_LEN);
   assign wr_dlo   = we && (addr == A_DLO);
   assign wr_dhi   = we && (addr == A_DHI);
   assign wr_cfg   = we && (addr == A_CFG);
   assign wr_order = we && (addr == A_ORDER);
   assign wr_req   = we && (addr == A_REQ);
   assign wr_ack   = we && (addr == A_ACK);

   // Message content: frozen while a message is being sent.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q     <= 1'b0;
         id_q      <= '0;
         len_code  <= '0;
         data_lo   <= '0;
         data_hi   <= '0;
         order_lsb <= 1'b0;
      end else if (!busy) begin
         if (wr_ident) begin
            ext_q <= wdata[WORD_W-1];
            id_q  <= wdata[ID_W-1:0];
         end
         if (wr_len)   len_code  <= wdata[LEN_W-1:0];
         if (wr_dlo)   data_lo   <= wdata;
         if (wr_dhi)   data_hi   <= wdata;
         if (wr_order) order_lsb <= wdata[0];
      end
   end

   // Mailbox configuration.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mb_en  <= 1'b0;
         mb_dir <= 1'b0;
      end else if (wr_cfg) begin
         mb_en  <= wdata[0];
         mb_dir <= wdata[1];
      end
   end

   // Request: set by software (write 1), cleared by completion.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 req <= 1'b0;
      else if (wr_req && wdata[0]) req <= 1'b1;
      else if (done)              req <= 1'b0;
   end

   // Acknowledge: set by completion, cleared by software (write 1).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ack <= 1'b0;
      else if (done)               ack <= 1'b1;
      else if (wr_ack && wdata[0]) ack <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_IDENT: rdata = id_word;
         A_LEN:   rdata = WORD_W'(len_code);
         A_DLO:   rdata = data_lo;
         A_DHI:   rdata = data_hi;
         A_CFG:   rdata = WORD_W'({mb_dir, mb_en});
         A_ORDER: rdata = WORD_W'(order_lsb);
         A_REQ:   rdata = WORD_W'(req);
         A_ACK:   rdata = WORD_W'(ack);
         default: rdata = '0;
      endcase
   end

   assert_req_w0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wdata[0] && !done) |=> $stable(req));

   assert_ack_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ack);

   assert_req_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(wr_req && wdata[0])) |=> !req);

   assert_ack_w0_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && !wdata[0] && !done) |=> $stable(ack));

   assert_lock_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (wr_dlo || wr_dhi)) |=> ($stable(data_lo) && $stable(data_hi)));

   assert_lock_hdr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (wr_ident || wr_len || wr_order)) |=>
         ($stable(id_word) && $stable(len_code) && $stable(order_lsb)));

endmodule

// File: rtl/mbx_byte_pick.sv
module mbx_byte_pick #(
   parameter int WORD_W = 32,
   parameter int WORDS  = 2,
   parameter int LEN_W  = 4
) (
   input  logic [WORDS*WORD_W-1:0] words,
   input  logic                    order_lsb,
   input  logic [LEN_W-1:0]        idx,
   output logic [7:0]              byte_out
);

   localparam int BPW    = WORD_W / 8;
   localparam int LANES  = WORDS * BPW;
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

   logic [7:0] lanes [LANES];

   // Flatten the words into lanes: lane w*BPW+b is byte b of word w.
   for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar b = 0; b < BPW; b++) begin : g_byte
         assign lanes[w*BPW + b] = words[w*WORD_W + b*8 +: 8];
      end
   end

   logic [LEN_W-1:0] wsel, jpos, lpos, flat;

   always_comb begin
      wsel = idx / LEN_W'(BPW);
      jpos = idx % LEN_W'(BPW);
      lpos = order_lsb ? jpos : (LEN_W'(BPW - 1) - jpos);
      flat = wsel * LEN_W'(BPW) + lpos;
      byte_out = lanes[flat[LANE_W-1:0]];
   end

endmodule

// File: rtl/mbx_tx_seq.sv
module mbx_tx_seq
   import mbx_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int LEN_W     = 4,
   parameter int MAX_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              mb_en,
   input  logic              mb_dir,
   input  logic [LEN_W-1:0]  len_code,
   input  logic [WORD_W-1:0] id_word,
   output logic              hdr_valid,
   input  logic              hdr_ready,
   output logic [WORD_W-1:0] hdr_id,
   output logic [LEN_W-1:0]  hdr_len,
   output logic              byte_valid,
   input  logic              byte_ready,
   output logic [LEN_W-1:0]  byte_idx,
   output logic              busy,
   output logic              done
);

   seq_state_e       state;
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] n_eff;
   logic             start, last_byte, hdr_fire, byte_fire;

   assign n_eff = (len_code > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : len_code;

   assign start     = (state == S_IDLE) && req && mb_en && !mb_dir;
   assign hdr_valid = (state == S_HDR);
   assign byte_valid = (state == S_DATA);
   assign hdr_fire  = hdr_valid && hdr_ready;
   assign byte_fire = byte_valid && byte_ready;
   assign last_byte = (cnt == n_eff - LEN_W'(1));
   assign done      = (hdr_fire && (n_eff == '0)) || (byte_fire && last_byte);
   assign busy      = (state != S_IDLE);

   assign hdr_id   = id_word;
   assign hdr_len  = n_eff;
   assign byte_idx = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               state <= S_HDR;
               cnt   <= '0;
            end
            S_HDR: if (hdr_fire) begin
               state <= (n_eff == '0) ? S_IDLE : S_DATA;
            end
            S_DATA: if (byte_fire) begin
               if (last_byte) state <= S_IDLE;
               else           cnt   <= cnt + LEN_W'(1);
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_valid && byte_valid));

   assert_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_IDLE) && !(mb_en && !mb_dir)) |=> !hdr_valid);

   assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> (cnt < n_eff));

   assert_hdr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_id) && $stable(hdr_len)));

   assert_byte_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_idx)));

endmodule

// File: rtl/mbx_tx_byteseq.sv
module mbx_tx_byteseq
   import mbx_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int ID_W   = 29,
   parameter int LEN_W  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_we,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0]     bus_wdata,
   output logic [WORD_W-1:0]     bus_rdata,
   output logic                  hdr_valid,
   input  logic                  hdr_ready,
   output logic [WORD_W-1:0]     hdr_id,
   output logic [LEN_W-1:0]      hdr_len,
   output logic                  byte_valid,
   input  logic                  byte_ready,
   output logic [7:0]            byte_data
);

   localparam int WORDS     = 2;
   localparam int BPW       = WORD_W / 8;
   localparam int MAX_BYTES = WORDS * BPW;

   if (WORD_W % 8 != 0) begin : g_chk_word
      $error("WORD_W must be a whole number of bytes");
   end
   if ((BPW & (BPW - 1)) != 0) begin : g_chk_pow2
      $error("bytes per word must be a power of two");
   end
   if (ID_W > WORD_W - 1) begin : g_chk_id
      $error("identifier does not fit below the extended flag");
   end
   if (MAX_BYTES >= (1 << LEN_W)) begin : g_chk_len
      $error("LEN_W too narrow for the byte count");
   end

   logic [WORD_W-1:0] id_word, data_lo, data_hi;
   logic [LEN_W-1:0]  len_code, byte_idx;
   logic              mb_en, mb_dir, order_lsb, req, ack, busy, done;

   mbx_regfile #(.WORD_W(WORD_W), .ID_W(ID_W), .LEN_W(LEN_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (bus_we),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .rdata     (bus_rdata),
      .busy      (busy),
      .done      (done),
      .id_word   (id_word),
      .len_code  (len_code),
      .data_lo   (data_lo),
      .data_hi   (data_hi),
      .mb_en     (mb_en),
      .mb_dir    (mb_dir),
      .order_lsb (order_lsb),
      .req       (req),
      .ack       (ack)
   );

   mbx_tx_seq #(.WORD_W(WORD_W), .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req),
      .mb_en      (mb_en),
      .mb_dir     (mb_dir),
      .len_code   (len_code),
      .id_word    (id_word),
      .hdr_valid  (hdr_valid),
      .hdr_ready  (hdr_ready),
      .hdr_id     (hdr_id),
      .hdr_len    (hdr_len),
      .byte_valid (byte_valid),
      .byte_ready (byte_ready),
      .byte_idx   (byte_idx),
      .busy       (busy),
      .done       (done)
   );

   mbx_byte_pick #(.WORD_W(WORD_W), .WORDS(WORDS), .LEN_W(LEN_W)) u_pick (
      .words     ({data_hi, data_lo}),
      .order_lsb (order_lsb),
      .idx       (byte_idx),
      .byte_out  (byte_data)
   );

   assert_ack_no_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !hdr_valid && !byte_valid);

endmodule

// File: tb/mbx_tx_byteseq_tb.sv
module mbx_tx_byteseq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        hdr_valid, byte_valid;
   logic        hdr_ready = 1'b0;
   logic        byte_ready = 1'b0;
   logic [31:0] hdr_id;
   logic [3:0]  hdr_len;
   logic [7:0]  byte_data;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 0;

   logic [7:0]  got [16];
   int          got_n, hdr_n, stab_err, order_err;
   logic [31:0] g_id;
   logic [3:0]  g_len;

   mbx_tx_byteseq u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_id(hdr_id), .hdr_len(hdr_len),
      .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WATCHDOG && !finished) begin
         failures = failures + 1;
         $display("FAIL watchdog act=%0d exp=<%0d cycles", cyc, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [7:0] exp_byte(input logic [31:0] lo, input logic [31:0] hi,
                                           input logic ord, input int k);
      logic [31:0] w;
      int j, lane;
      w = (k < 4) ? lo : hi;
      j = k % 4;
      lane = ord ? j : 3 - j;
      return w[lane*8 +: 8];
   endfunction

   // Drives the sinks for a fixed window and records every handshake.
   task automatic collect(input int mode);
      bit pend_h = 0, pend_b = 0, rdy;
      logic [31:0] ph_id; logic [3:0] ph_len; logic [7:0] pb;
      got_n = 0; hdr_n = 0; stab_err = 0; order_err = 0;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         if (pend_h && (!hdr_valid || hdr_id !== ph_id || hdr_len !== ph_len)) stab_err++;
         if (pend_b && (!byte_valid || byte_data !== pb)) stab_err++;
         rdy = (mode == 0) ? 1'b1 : (mode == 1) ? (c % 2 == 0) : (c % 3 == 2);
         hdr_ready = rdy; byte_ready = rdy;
         if (hdr_valid && rdy) begin
            hdr_n++; g_id = hdr_id; g_len = hdr_len;
            if (got_n != 0) order_err++;
         end
         if (byte_valid && rdy) begin
            if (got_n < 16) got[got_n] = byte_data;
            got_n++;
            if (hdr_n == 0) order_err++;
         end
         if (hdr_valid && byte_valid) order_err++;
         pend_h = hdr_valid && !rdy; ph_id = hdr_id; ph_len = hdr_len;
         pend_b = byte_valid && !rdy; pb = byte_data;
      end
      @(negedge clk);
      hdr_ready = 1'b0; byte_ready = 1'b0;
   endtask

   task automatic check_msg(input string tag, input logic [31:0] lo, input logic [31:0] hi,
                            input logic ord, input int n, input logic [31:0] id);
      logic [63:0] a, e;
      logic [31:0] r;
      a = '0; e = '0;
      for (int k = 0; k < 8; k++) begin
         if (k < got_n) a[63-8*k -: 8] = got[k];
         if (k < n)     e[63-8*k -: 8] = exp_byte(lo, hi, ord, k);
      end
      chk({tag, " byte count"}, 64'(got_n), 64'(n));
      chk({tag, " byte sequence"}, a, e);
      chk({tag, " R5 header count"}, 64'(hdr_n), 64'd1);
      chk({tag, " R5 header id"}, 64'(g_id), 64'(id));
      chk({tag, " R5 header len"}, 64'(g_len), 64'(n));
      chk({tag, " R5 header before bytes"}, 64'(order_err), 64'd0);
      chk({tag, " R12 hold while stalled"}, 64'(stab_err), 64'd0);
      rd(3'd7, r); chk({tag, " R10 ack set"}, 64'(r), 64'd1);
      rd(3'd6, r); chk({tag, " R10 request cleared"}, 64'(r), 64'd0);
   endtask

   task automatic load(input logic [31:0] lo, input logic [31:0] hi,
                       input logic ord, input logic [31:0] len);
      wr(3'd7, 32'h1);
      wr(3'd2, lo); wr(3'd3, hi); wr(3'd5, 32'(ord)); wr(3'd1, len);
   endtask

   task automatic t_reset;
      logic [31:0] r;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), r);
         chk($sformatf("R1 reset reg %0d", a), 64'(r), 64'd0);
      end
      chk("R1 reset valids", 64'({hdr_valid, byte_valid}), 64'd0);
   endtask

   task automatic t_regs;
      logic [31:0] r;
      wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, r); chk("R2 ident pad bits", 64'(r), 64'h9FFF_FFFF);
      wr(3'd0, 32'h8000_0011); rd(3'd0, r); chk("R2 ident ext", 64'(r), 64'h8000_0011);
      wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, r); chk("R2 length field", 64'(r), 64'hF);
      wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, r); chk("R2 config field", 64'(r), 64'h3);
      wr(3'd5, 32'hFFFF_FFFE); rd(3'd5, r); chk("R2 order field", 64'(r), 64'h0);
      wr(3'd4, 32'h0);
   endtask

   task automatic t_gate_lsb;
      logic [31:0] r;
      int seen = 0;
      load(32'h0403_0201, 32'h0807_0605, 1'b1, 32'd8);
      wr(3'd6, 32'h1); rd(3'd6, r); chk("R3 request set", 64'(r), 64'd1);
      wr(3'd6, 32'h0); rd(3'd6, r); chk("R3 write 0 keeps request", 64'(r), 64'd1);
      for (int c = 0; c < 20; c++) begin @(negedge clk); if (hdr_valid || byte_valid) seen++; end
      chk("R4 disabled sends nothing", 64'(seen), 64'd0);
      wr(3'd4, 32'h3); seen = 0;
      for (int c = 0; c < 20; c++) begin @(negedge clk); if (hdr_valid || byte_valid) seen++; end
      chk("R4 receive direction sends nothing", 64'(seen), 64'd0);
      rd(3'd6, r); chk("R4 request still pending", 64'(r), 64'd1);
      wr(3'd4, 32'h1);
      collect(0);
      check_msg("R6 lsb-first", 32'h0403_0201, 32'h0807_0605, 1'b1, 8, 32'h8000_0011);
   endtask

   task automatic t_msb_stall;
      load(32'h0403_0201, 32'h0807_0605, 1'b0, 32'd8);
      wr(3'd6, 32'h1);
      collect(1);
      check_msg("R7 msb-first alt-ready", 32'h0403_0201, 32'h0807_0605, 1'b0, 8, 32'h8000_0011);
   endtask

   task automatic t_lengths;
      load(32'hA3A2_A1A0, 32'hB3B2_B1B0, 1'b1, 32'd5);
      wr(3'd6, 32'h1); collect(2);
      check_msg("R8 length 5", 32'hA3A2_A1A0, 32'hB3B2_B1B0, 1'b1, 5, 32'h8000_0011);
      load(32'hA3A2_A1A0, 32'hB3B2_B1B0, 1'b0, 32'd13);
      wr(3'd6, 32'h1); collect(0);
      check_msg("R8 length 13 clamped", 32'hA3A2_A1A0, 32'hB3B2_B1B0, 1'b0, 8, 32'h8000_0011);
      load(32'hA3A2_A1A0, 32'hB3B2_B1B0, 1'b0, 32'd0);
      wr(3'd0, 32'h0000_0123);
      wr(3'd6, 32'h1); collect(0);
      check_msg("R9 length 0", 32'hA3A2_A1A0, 32'hB3B2_B1B0, 1'b0, 0, 32'h0000_0123);
   endtask

   task automatic t_ack;
      logic [31:0] r;
      wr(3'd7, 32'hFFFF_FFFE); rd(3'd7, r); chk("R10 ack write 0 ignored", 64'(r), 64'd1);
      wr(3'd7, 32'h1);         rd(3'd7, r); chk("R10 ack write 1 clears", 64'(r), 64'd0);
   endtask

   task automatic t_lock;
      logic [31:0] r;
      load(32'h0403_0201, 32'h0807_0605, 1'b1, 32'd8);
      wr(3'd0, 32'h8000_0011);
      wr(3'd6, 32'h1);
      repeat (3) @(negedge clk);
      wr(3'd2, 32'hDEAD_BEEF); wr(3'd5, 32'h0); wr(3'd1, 32'd2); wr(3'd0, 32'h0000_0055);
      rd(3'd2, r); chk("R11 low word locked", 64'(r), 64'h0403_0201);
      rd(3'd5, r); chk("R11 order locked", 64'(r), 64'd1);
      rd(3'd1, r); chk("R11 length locked", 64'(r), 64'd8);
      rd(3'd0, r); chk("R11 ident locked", 64'(r), 64'h8000_0011);
      collect(0);
      check_msg("R11 message unchanged", 32'h0403_0201, 32'h0807_0605, 1'b1, 8, 32'h8000_0011);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_gate_lsb();
      t_msb_stall();
      t_lengths();
      t_ack();
      t_lock();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule